// File: doc/BRIEF.md
# Eleven-instruction RISC-V integer core

This block is a single-cycle processor for a small subset of the 32-bit RISC-V integer instruction set. In each clock it presents the program counter on the fetch port, and it decodes the 32-bit word that comes back in the same cycle. It then reads two operands from an eight-entry register file, computes a result, and in the same cycle commits the register write, the store and the next program counter. Fetch and data memories are outside the block and answer combinationally. Stores are written at the clock edge that ends the cycle.

The supported operations are register-register add, subtract, AND, OR and XOR, add-immediate, word load, word store, the equal and not-equal branches, and the register-indirect jump with link. Any other encoding halts the core. This includes an unknown opcode, an unsupported function code, a register field that names x8 or higher, the all-zeros word, and a load or store whose address is not a multiple of four. When it halts, the core raises both of its flags, commits nothing from the offending instruction, and stays frozen until reset.

Top module: `rvl_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0, clears every register to 0, and drives halted, illegal and the store strobe low.
- R2: Opcode 0110011 performs rd = rs1 op rs2. With funct7 0000000, funct3 000 gives add, 111 gives AND, 110 gives OR and 100 gives XOR. With funct7 0100000 and funct3 000 it gives rs1 minus rs2.
- R3: Opcode 0010011 with funct3 000 writes rs1 + sign-extended bits [31:20] to rd. The bits in the rs2 field position belong to the immediate and are never checked as a register index.
- R4: A load (opcode 0000011, funct3 010) and a store (opcode 0100011, funct3 010) use the address rs1 + offset. The load offset is bits [31:20]; the store offset is {bits[31:25], bits[11:7]}; both are sign-extended. A load writes the 32-bit memory word to rd. A store raises the write strobe for exactly that cycle, with the rs2 value as write data.
- R5: Opcode 1100011 compares rs1 with rs2, with funct3 000 for equal and 001 for not-equal. If the condition holds, the next PC is PC + {bit31, bit7, bits[30:25], bits[11:8], 0}, sign-extended; otherwise it is PC + 4. Backward offsets are supported.
- R6: Opcode 1100111 with funct3 000 jumps to (rs1 + sign-extended bits [31:20]) with bit 0 cleared, and writes PC + 4 to rd. The target is computed from the rs1 value before the write, so the result is correct when rd equals rs1.
- R7: Register x0 always reads as 0. A write to x0 is discarded.
- R8: The core halts on any of these: an opcode not listed above, a funct3 or funct7 value not listed above, a used register field of 01000 or higher, or the all-zeros word. On halt it raises halted and illegal, and it leaves the PC, the registers and memory unchanged.
- R9: A load or store whose address has nonzero low two bits halts the core as in R8, and no memory write takes place.
- R10: Once halted, the core keeps the PC frozen, never raises the store strobe, and keeps both flags high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at imem_addr, returned in the same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_we | output | 1 | Store strobe; memory writes at the next rising edge |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Word at dmem_addr, returned in the same cycle |
| halted | output | 1 | Execution has stopped; remains high until reset |
| illegal | output | 1 | An unsupported or misaligned instruction was met; remains high until reset |

## Verification
The assertions rely on both memories answering within the cycle and with defined data. They also rely on reset being held for at least one rising edge before the first instruction is fetched. The testbench keeps within these limits with behavioural memories of 64 words each. A fetch beyond the program area returns the all-zeros word, so every run ends in a deliberate halt. The bench sets reset and loads programs only between runs, away from the active edge. Data addresses in the test programs stay inside the modelled window, and the window is aliased in the same way in the bench's reference model.

// File: rtl/rvl_pkg.sv
package rvl_pkg;
  localparam int XLEN = 32;

  localparam logic [6:0] OPC_ALU    = 7'b0110011;
  localparam logic [6:0] OPC_ADDI   = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {K_ALU, K_ADDI, K_LOAD, K_STORE, K_BRANCH, K_JALR, K_BAD} kind_e;
  typedef enum logic [2:0] {A_ADD, A_SUB, A_AND, A_OR, A_XOR} aluop_e;

  // Immediate builders; every one takes its sign from instruction bit 31.
  function automatic logic [XLEN-1:0] imm_i(input logic [31:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

  function automatic logic [XLEN-1:0] imm_s(input logic [31:0] w);
    return {{20{w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [XLEN-1:0] imm_b(input logic [31:0] w);
    return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  // Subtraction reuses the adder with the second operand inverted and a carry-in of one.
  function automatic logic [XLEN-1:0] alu_eval(input aluop_e op, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    unique case (op)
      A_SUB:   y = a + ~b + XLEN'(1);
      A_AND:   y = a & b;
      A_OR:    y = a | b;
      A_XOR:   y = a ^ b;
      default: y = a + b;
    endcase
    return y;
  endfunction
endpackage

// File: rtl/rvl_decode.sv
module rvl_decode
  import rvl_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic [31:0]     instr,
  output kind_e           kind,
  output aluop_e          aluop,
  output logic [XLEN-1:0] imm,
  output logic [IW-1:0]   rd,
  output logic [IW-1:0]   rs1,
  output logic [IW-1:0]   rs2,
  output logic            rd_wr,
  output logic            bad
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [4:0] rd_f, rs1_f, rs2_f;
  logic       use_rd, use_rs1, use_rs2;

  assign opc   = instr[6:0];
  assign f3    = instr[14:12];
  assign f7    = instr[31:25];
  assign rd_f  = instr[11:7];
  assign rs1_f = instr[19:15];
  assign rs2_f = instr[24:20];
  assign rd    = rd_f[IW-1:0];
  assign rs1   = rs1_f[IW-1:0];
  assign rs2   = rs2_f[IW-1:0];

  function automatic logic idx_ok(input logic [4:0] f);
    return int'(f) < NREG;
  endfunction

  always_comb begin
    kind    = K_BAD;
    aluop   = A_ADD;
    imm     = imm_i(instr);
    use_rd  = 1'b0;
    use_rs1 = 1'b0;
    use_rs2 = 1'b0;
    unique case (opc)
      OPC_ALU: begin
        use_rd = 1'b1; use_rs1 = 1'b1; use_rs2 = 1'b1;
        if (f7 == 7'b0000000) begin
          kind = K_ALU;
          unique case (f3)
            3'b000:  aluop = A_ADD;
            3'b111:  aluop = A_AND;
            3'b110:  aluop = A_OR;
            3'b100:  aluop = A_XOR;
            default: kind = K_BAD;
          endcase
        end else if (f7 == 7'b0100000 && f3 == 3'b000) begin
          kind  = K_ALU;
          aluop = A_SUB;
        end
      end
      OPC_ADDI: begin
        use_rd = 1'b1; use_rs1 = 1'b1;
        if (f3 == 3'b000) kind = K_ADDI;
      end
      OPC_LOAD: begin
        use_rd = 1'b1; use_rs1 = 1'b1;
        if (f3 == 3'b010) kind = K_LOAD;
      end
      OPC_STORE: begin
        use_rs1 = 1'b1; use_rs2 = 1'b1;
        imm = imm_s(instr);
        if (f3 == 3'b010) kind = K_STORE;
      end
      OPC_BRANCH: begin
        use_rs1 = 1'b1; use_rs2 = 1'b1;
        imm = imm_b(instr);
        if (f3 == 3'b000 || f3 == 3'b001) kind = K_BRANCH;
      end
      OPC_JALR: begin
        use_rd = 1'b1; use_rs1 = 1'b1;
        if (f3 == 3'b000) kind = K_JALR;
      end
      default: kind = K_BAD;
    endcase
  end

  assign bad = (kind == K_BAD) || (use_rd && !idx_ok(rd_f)) ||
               (use_rs1 && !idx_ok(rs1_f)) || (use_rs2 && !idx_ok(rs2_f));
  assign rd_wr = use_rd && !bad && (rd_f != 5'd0);
endmodule

// File: rtl/rvl_regfile.sv
module rvl_regfile #(
  parameter int NREG = 8,
  parameter int W = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [IW-1:0] ra2,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] cells [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : cells[ra1];
  assign rd2 = (ra2 == '0) ? '0 : cells[ra2];

  // R7: the decoder must never route a write to the zero register
  p_x0_write_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr != '0));
endmodule

// File: rtl/rvl_alu.sv
module rvl_alu
  import rvl_pkg::*;
(
  input  aluop_e          op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/rvl_core.sv
module rvl_core
  import rvl_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic        dmem_we,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata,
  output logic        halted,
  output logic        illegal
);
  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, rs1_v, rs2_v, alu_b, alu_y, wb_data, imm;
  logic            halt_q, ill_q;
  kind_e           kind;
  aluop_e          aluop;
  logic [IW-1:0]   rd, rs1, rs2;
  logic            rd_wr, bad, misaligned, fault, commit, taken;

  rvl_decode #(.NREG(NREG)) u_dec (
    .instr(imem_rdata), .kind(kind), .aluop(aluop), .imm(imm),
    .rd(rd), .rs1(rs1), .rs2(rs2), .rd_wr(rd_wr), .bad(bad)
  );

  rvl_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst), .we(commit && rd_wr), .waddr(rd), .wdata(wb_data),
    .ra1(rs1), .rd1(rs1_v), .ra2(rs2), .rd2(rs2_v)
  );

  assign alu_b = (kind == K_ALU) ? rs2_v : imm;

  rvl_alu u_alu (.op(aluop), .a(rs1_v), .b(alu_b), .y(alu_y));

  // Named events used by the assertions below
  assign misaligned = (kind == K_LOAD || kind == K_STORE) && (alu_y[1:0] != 2'b00);
  assign fault      = bad || misaligned;
  assign commit     = !halt_q && !fault;
  assign taken      = (kind == K_BRANCH) && ((rs1_v == rs2_v) ^ imem_rdata[12]);
  assign pc_plus4   = pc_q + XLEN'(4);

  always_comb begin
    unique case (kind)
      K_LOAD:  wb_data = dmem_rdata;
      K_JALR:  wb_data = pc_plus4;
      default: wb_data = alu_y;
    endcase
  end

  always_comb begin
    pc_next = pc_plus4;
    if (kind == K_JALR)  pc_next = {alu_y[XLEN-1:1], 1'b0};
    else if (taken)      pc_next = pc_q + imm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
      ill_q  <= 1'b0;
    end else if (!halt_q) begin
      if (fault) begin
        halt_q <= 1'b1;
        ill_q  <= 1'b1;
      end else begin
        pc_q <= pc_next;
      end
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_v;
  assign dmem_we    = commit && (kind == K_STORE) && !rst;
  assign halted     = halt_q;
  assign illegal    = ill_q;

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);
  p_pc_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> $stable(pc_q));
  p_no_store_halted_r10: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> !dmem_we);
  p_store_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (dmem_addr[1:0] == 2'b00));
  p_fault_halts_r8: assert property (@(posedge clk) disable iff (rst)
    (!halt_q && fault) |=> (halt_q && ill_q && $stable(pc_q)));
  p_flags_agree_r8: assert property (@(posedge clk) disable iff (rst)
    halt_q == ill_q);
  p_pc_even_r6: assert property (@(posedge clk) disable iff (rst)
    pc_q[0] == 1'b0);
endmodule

// File: tb/rvl_core_test.sv
`timescale 1ns/1ps
module rvl_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, halted, illegal;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] ref_dmem [64];
  logic [31:0] ref_x [8];
  string       reg_tag [8];
  logic [31:0] ref_pc;
  logic        ref_halt, ref_ill, rst_at_edge;
  string       pc_tag, halt_tag;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  rvl_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .halted(halted), .illegal(illegal)
  );

  assign imem_rdata = (imem_addr < 32'd256) ? imem[imem_addr[7:2]] : 32'h0;
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  always @(posedge clk) rst_at_edge <= rst;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Instruction encoders
  function automatic logic [31:0] r_t(input logic [6:0] f7, input int s2, input int s1,
                                      input logic [2:0] f3, input int d);
    return {f7, 5'(s2), 5'(s1), f3, 5'(d), 7'b0110011};
  endfunction
  function automatic logic [31:0] i_t(input int im, input int s1, input logic [2:0] f3,
                                      input int d, input logic [6:0] op);
    logic [11:0] v = 12'(im);
    return {v, 5'(s1), f3, 5'(d), op};
  endfunction
  function automatic logic [31:0] s_t(input int im, input int s2, input int s1);
    logic [11:0] v = 12'(im);
    return {v[11:5], 5'(s2), 5'(s1), 3'b010, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] b_t(input int im, input int s2, input int s1,
                                      input logic [2:0] f3);
    logic [12:0] v = 13'(im);
    return {v[12], v[10:5], 5'(s2), 5'(s1), f3, v[4:1], v[11], 7'b1100011};
  endfunction

  task automatic model_reset();
    ref_pc = 0; ref_halt = 0; ref_ill = 0; pc_tag = "R1"; halt_tag = "R8";
    for (int i = 0; i < 8; i++) begin ref_x[i] = 0; reg_tag[i] = "R1"; end
    reg_tag[0] = "R7";
  endtask

  // One architectural step of the reference model, after comparing the DUT against it
  task automatic model_step();
    logic [31:0] ins, a, b, ea, immi, imms, immb, res;
    int k, d, s1, s2;
    bit regs_ok, fault, mis, exp_we;
    ins  = (ref_pc < 256) ? imem[ref_pc[7:2]] : 32'h0;
    d = int'(ins[11:7]); s1 = int'(ins[19:15]); s2 = int'(ins[24:20]);
    immi = {{20{ins[31]}}, ins[31:20]};
    imms = {{20{ins[31]}}, ins[31:25], ins[11:7]};
    immb = 32'(signed'({ins[31], ins[7], ins[30:25], ins[11:8], 1'b0}));
    casez (ins)
      32'b0000000_?????_?????_000_?????_0110011, 32'b0100000_?????_?????_000_?????_0110011,
      32'b0000000_?????_?????_111_?????_0110011, 32'b0000000_?????_?????_110_?????_0110011,
      32'b0000000_?????_?????_100_?????_0110011: k = 1;
      32'b????????????_?????_000_?????_0010011: k = 2;
      32'b????????????_?????_010_?????_0000011: k = 3;
      32'b???????_?????_?????_010_?????_0100011: k = 4;
      32'b???????_?????_?????_00?_?????_1100011: k = 5;
      32'b????????????_?????_000_?????_1100111: k = 6;
      default: k = 0;
    endcase
    regs_ok = 1;
    if (k != 4 && k != 5 && d > 7) regs_ok = 0;
    if (s1 > 7) regs_ok = 0;
    if ((k == 1 || k == 4 || k == 5) && s2 > 7) regs_ok = 0;
    a = (s1 < 8) ? ref_x[s1] : 0;
    b = (s2 < 8) ? ref_x[s2] : 0;
    ea = a + ((k == 4) ? imms : immi);
    mis = (k == 3 || k == 4) && (ea % 4 != 0);
    fault = (k == 0) || !regs_ok || mis;
    exp_we = !ref_halt && !fault && k == 4;

    chk(imem_addr == ref_pc, ref_halt ? "R10" : pc_tag, "pc", imem_addr, ref_pc);
    chk(halted == ref_halt, halt_tag, "halted", 32'(halted), 32'(ref_halt));
    chk(illegal == ref_ill, halt_tag, "illegal", 32'(illegal), 32'(ref_ill));
    chk(dmem_we == exp_we, ref_halt ? "R10" : (mis ? "R9" : "R4"), "store strobe",
        32'(dmem_we), 32'(exp_we));
    if (exp_we && dmem_we) begin
      chk(dmem_addr == ea, "R4", "store address", dmem_addr, ea);
      chk(dmem_wdata == b, reg_tag[s2], "store data", dmem_wdata, b);
    end

    if (ref_halt) return;
    if (fault) begin
      ref_halt = 1; ref_ill = 1; halt_tag = mis ? "R9" : "R8";
      return;
    end
    pc_tag = "R3";
    case (k)
      1: begin
        case ({ins[30], ins[14:12]})
          4'b1000: res = a - b;
          4'b0111: res = a & b;
          4'b0110: res = a | b;
          4'b0100: res = a ^ b;
          default: res = a + b;
        endcase
        if (d != 0) begin ref_x[d] = res; reg_tag[d] = "R2"; end
        ref_pc = ref_pc + 4;
      end
      2: begin
        if (d != 0) begin ref_x[d] = a + immi; reg_tag[d] = "R3"; end
        ref_pc = ref_pc + 4;
      end
      3: begin
        if (d != 0) begin ref_x[d] = ref_dmem[ea[7:2]]; reg_tag[d] = "R4"; end
        ref_pc = ref_pc + 4; pc_tag = "R4";
      end
      4: begin
        ref_dmem[ea[7:2]] = b;
        ref_pc = ref_pc + 4; pc_tag = "R4";
      end
      5: begin
        if ((a == b) != ins[12]) ref_pc = ref_pc + immb;
        else ref_pc = ref_pc + 4;
        pc_tag = "R5";
      end
      default: begin
        res = ref_pc + 4;
        ref_pc = (a + immi) & ~32'd1;
        if (d != 0) begin ref_x[d] = res; reg_tag[d] = "R6"; end
        pc_tag = "R6";
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (rst) begin
      model_reset();
      if (rst_at_edge) begin
        chk(imem_addr == 0, "R1", "reset pc", imem_addr, 0);
        chk(!halted && !illegal, "R1", "reset flags", {halted, illegal}, 0);
        chk(!dmem_we, "R1", "reset strobe", 32'(dmem_we), 0);
      end
    end else begin
      model_step();
    end
  end

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin imem[i] = 0; dmem[i] = 0; ref_dmem[i] = 0; end
  endtask

  task automatic start_run(input int n);
    repeat (2) @(posedge clk);
    #1 rst = 0;
    repeat (n) @(posedge clk);
    #1 rst = 1;
  endtask

  task automatic prog_main();
    clear_prog();
    imem[0]  = s_t(32'h60, 7, 0);                     // R1: x7 after reset is zero
    imem[1]  = i_t(5, 0, 3'b000, 1, 7'b0010011);      // R3
    imem[2]  = i_t(-3, 0, 3'b000, 2, 7'b0010011);     // R3: immediate bits fill rs2 slot
    imem[3]  = r_t(7'h00, 2, 1, 3'b000, 3);           // R2 add
    imem[4]  = r_t(7'h20, 2, 1, 3'b000, 4);           // R2 sub
    imem[5]  = r_t(7'h00, 2, 1, 3'b111, 5);           // R2 and
    imem[6]  = r_t(7'h00, 2, 1, 3'b110, 6);           // R2 or
    imem[7]  = r_t(7'h00, 2, 1, 3'b100, 7);           // R2 xor
    imem[8]  = s_t(32'h40, 3, 0);
    imem[9]  = s_t(32'h44, 4, 0);
    imem[10] = s_t(32'h48, 5, 0);
    imem[11] = s_t(32'h4C, 6, 0);
    imem[12] = s_t(32'h50, 7, 0);
    imem[13] = i_t(32'h44, 0, 3'b010, 1, 7'b0000011); // R4 load
    imem[14] = s_t(32'h54, 1, 0);
    imem[15] = b_t(8, 4, 1, 3'b000);                  // R5 beq taken
    imem[16] = i_t(99, 0, 3'b000, 7, 7'b0010011);     // skipped
    imem[17] = b_t(8, 4, 1, 3'b001);                  // R5 bne not taken
    imem[18] = i_t(3, 0, 3'b000, 5, 7'b0010011);
    imem[19] = i_t(-1, 5, 3'b000, 5, 7'b0010011);
    imem[20] = b_t(-4, 0, 5, 3'b001);                 // R5 backward loop
    imem[21] = s_t(32'h58, 5, 0);
    imem[22] = i_t(99, 0, 3'b000, 6, 7'b0010011);
    imem[23] = i_t(1, 6, 3'b000, 6, 7'b1100111);      // R6 jalr, rd == rs1
    imem[24] = i_t(77, 0, 3'b000, 7, 7'b0010011);     // skipped
    imem[25] = s_t(32'h5C, 6, 0);
    imem[26] = i_t(7, 0, 3'b000, 0, 7'b0010011);      // R7 write to x0
    imem[27] = s_t(32'h64, 0, 0);
    imem[28] = i_t(64, 0, 3'b000, 2, 7'b0010011);
    imem[29] = i_t(8, 2, 3'b010, 3, 7'b0000011);
    imem[30] = s_t(-4, 3, 2);                         // R4 negative store offset
    imem[31] = 32'h0;                                 // R8 all-zeros word halts
    start_run(60);
  endtask

  task automatic prog_bad(input logic [31:0] w);
    clear_prog();
    imem[0] = i_t(4, 0, 3'b000, 1, 7'b0010011);
    imem[1] = w;
    imem[2] = s_t(32'h40, 1, 0);
    start_run(8);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clear_prog();
    @(posedge clk); #1;
    prog_main();
    prog_bad(r_t(7'h01, 2, 1, 3'b000, 3));            // R8 bad funct7
    prog_bad(r_t(7'h20, 2, 1, 3'b111, 3));            // R8 sub code with other funct3
    prog_bad({25'h0, 7'b0110111});                    // R8 unsupported opcode
    prog_bad(i_t(1, 0, 3'b000, 8, 7'b0010011));       // R8 rd = x8
    prog_bad(r_t(7'h00, 8, 1, 3'b000, 3));            // R8 rs2 = x8
    prog_bad(s_t(0, 1, 9));                           // R8 rs1 = x9
    prog_bad(i_t(1, 1, 3'b001, 2, 7'b0010011));       // R8 immediate funct3 001
    prog_bad(b_t(8, 0, 1, 3'b100));                   // R8 branch funct3 100
    prog_bad(i_t(0, 1, 3'b001, 2, 7'b1100111));       // R8 jump funct3 001
    prog_bad(i_t(1, 1, 3'b010, 2, 7'b0000011));       // R9 misaligned load
    prog_bad(s_t(2, 1, 0));                           // R9 misaligned store
    prog_bad(32'h0);                                  // R8 all zeros
    prog_main();                                      // R1 registers cleared again
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule